// File: doc/BRIEF.md
# Power Partition Gating Sequencer

This block switches single power partitions of a small chip on or off. A request names a logical group and a target state (on or off). The block looks the group up in a fixed table, at elaboration time, that gives its physical partition number. It then drives the partition's reset, clock enable, power-switch command and isolation-release command in a fixed order. It waits for the switch to report power-good and for the isolation cells to finish releasing. The power-good vector, one bit per physical partition, is an input from the switch model. So is the per-bit isolation acknowledge.

A group can be marked as not gateable. Requests for such a group, or for an index past the last group, are ignored, and the group always reads as powered. Two table entries can be marked as swapped. Their isolation-release mask then uses the other entry's partition bit. After reset the block walks every group in index order and gates each supported one off before it takes any request. Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A source that holds `req_valid` while ready is low is simply stalled. Nothing is queued.

Top module: `pgate_seq`

## Requirements
- R1: While reset is held, `part_rst`, `part_clk_en`, `clamp_cmd`, `done` and `req_ready` are all zero. After reset the supported groups (0, 1 and 3 by default, on partitions 1, 4 and 5) are gated off one after another without any `done` pulse. With all partitions powered at start, this leaves `pwr_status` at 8'hCD and `part_rst` at 8'h32 once `req_ready` rises.
- R2: A request whose target already equals the partition's `pwr_status` bit does nothing to any output. It completes with `done` high in the cycle after the first busy cycle.
- R3: A request naming a group marked not gateable (group 2), or an index of 4 or more, is ignored with the same one-cycle completion. A group marked not gateable always reads 1 on `grp_on`.
- R4: Gate-off asserts the partition's `part_rst` bit. In the second busy cycle it issues a single-cycle `pwr_tog_cmd` with bit 3 (start) set and bits 2:0 holding the partition number. It then waits for that `pwr_status` bit to fall. `done` follows one cycle after the bit falls, and `part_rst` stays asserted.
- R5: Gate-on holds reset and issues the same toggle. Two cycles after `pwr_status` rises, it raises `part_clk_en` for that partition while reset is still asserted.
- R6: The isolation-release command rises exactly RST_DLY+1 cycles after the clock enable rises (RST_DLY defaults to 4).
- R7: The isolation-release command is one-hot and clears bit by bit only on `clamp_ack`. Groups 0 and 1 are swapped, so group 0 issues bit 4 and group 1 issues bit 1, while group 3 issues bit 5.
- R8: `part_rst` falls two cycles after `clamp_cmd` reads zero. `part_clk_en` falls one cycle later, in the same cycle as `done`.
- R9: `busy` is high from acceptance until the sequence ends. Requests presented meanwhile are refused and leave no trace.
- R10: `done` is high for exactly one cycle per accepted request.
- R11: For a supported group, `grp_on` follows that partition's `pwr_status` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_group | input | GIDX_W | Logical group index |
| req_on | input | 1 | Target state, 1 = powered |
| busy | output | 1 | A sequence (including the reset sweep) is running |
| done | output | 1 | One-cycle completion pulse for an accepted request |
| pwr_tog_cmd | output | ID_W+1 | Power toggle command: start bit on top, partition number below |
| pwr_status | input | N_PART | Power-good per physical partition |
| clamp_cmd | output | N_PART | Isolation-release command, self-clearing |
| clamp_ack | input | N_PART | Isolation release finished, per bit |
| part_rst | output | N_PART | Reset hold per partition |
| part_clk_en | output | N_PART | Clock enable per partition |
| grp_on | output | N_GROUPS | Power state seen per logical group |

## Verification
Every result of a sequence is due a fixed number of cycles after a preceding event. The toggle command appears two cycles after busy rises. The clock enable rises two cycles after power-good changes. The isolation command follows the clock enable by RST_DLY+1 cycles. Reset drops two cycles after the isolation command empties, and the clock enable and `done` come one cycle after that. The bench records the cycle number of every edge on each output at the falling clock edge. For every request it compares those recorded cycles against these offsets, so the checks do not depend on the latency of the bench's switch and isolation models. No-op and ignored requests are checked for a `done` one cycle after busy rises and for no toggle or reset change at all.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  typedef enum logic [3:0] {
    S_INIT,
    S_IDLE,
    S_CHECK,
    S_TOGGLE,
    S_WAITPWR,
    S_CLKON,
    S_DELAY,
    S_CLAMP,
    S_CLWAIT,
    S_RSTOFF,
    S_CLKOFF,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/pgate_map.sv
module pgate_map #(
  parameter int N_GROUPS = 4,
  parameter int GIDX_W   = 3,
  parameter int ID_W     = 3,
  parameter int N_PART   = 8,
  parameter logic [N_GROUPS*ID_W-1:0] GROUP_ID = {3'd5, 3'd2, 3'd4, 3'd1},
  parameter logic [N_GROUPS-1:0] GROUP_OK = 4'b1011,
  parameter int SWAP_A = 0,
  parameter int SWAP_B = 1
) (
  input  logic [GIDX_W-1:0]   sel,
  input  logic [N_PART-1:0]   pwr_status,
  output logic                sel_ok,
  output logic [ID_W-1:0]     sel_id,
  output logic [N_PART-1:0]   sel_mask,
  output logic [N_GROUPS-1:0] grp_on
);

  logic [N_PART-1:0] mask_tab [N_GROUPS];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_tab
    localparam int SRC = (g == SWAP_A) ? SWAP_B : ((g == SWAP_B) ? SWAP_A : g);
    assign mask_tab[g] = N_PART'(1) << GROUP_ID[SRC*ID_W +: ID_W];
    assign grp_on[g]   = ~GROUP_OK[g] | pwr_status[GROUP_ID[g*ID_W +: ID_W]];
  end

  always_comb begin
    sel_ok   = 1'b0;
    sel_id   = '0;
    sel_mask = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (sel == GIDX_W'(g)) begin
        sel_ok   = GROUP_OK[g];
        sel_id   = GROUP_ID[g*ID_W +: ID_W];
        sel_mask = mask_tab[g];
      end
    end
  end

endmodule

// File: rtl/pgate_delay.sv
module pgate_delay #(
  parameter int RST_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);

  localparam int DLY_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= DLY_W'(RST_DLY - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pgate_clamp.sv
module pgate_clamp #(
  parameter int N_PART = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [N_PART-1:0] mask,
  input  logic [N_PART-1:0] ack,
  output logic [N_PART-1:0] cmd,
  output logic              idle
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0;
    end else begin
      cmd <= (cmd & ~ack) | (set ? mask : '0);
    end
  end

  assign idle = (cmd == '0);

  // R7
  clamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  for (genvar i = 0; i < N_PART; i++) begin : g_ack
    // R7
    clamp_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd[i]) |-> $past(ack[i]));
  end

endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm
  import pgate_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int GIDX_W   = 3,
  parameter int ID_W     = 3,
  parameter int N_PART   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [GIDX_W-1:0] req_group,
  input  logic              req_on,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [GIDX_W-1:0] cur_group,
  input  logic              grp_ok,
  input  logic [ID_W-1:0]   grp_id,
  input  logic [N_PART-1:0] pwr_status,
  output logic [ID_W:0]     tog_cmd,
  output logic              clamp_set,
  input  logic              clamp_idle,
  output logic              dly_load,
  input  logic              dly_zero,
  output logic [N_PART-1:0] part_rst,
  output logic [N_PART-1:0] part_clk_en
);

  localparam int INIT_W = $clog2(N_GROUPS + 1);

  seq_state_e        state;
  logic [INIT_W-1:0] init_idx;
  logic              tgt_on;
  logic              ext;
  logic              cur_on;

  assign cur_on = pwr_status[grp_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_INIT;
      init_idx    <= '0;
      cur_group   <= '0;
      tgt_on      <= 1'b0;
      ext         <= 1'b0;
      tog_cmd     <= '0;
      part_rst    <= '0;
      part_clk_en <= '0;
    end else begin
      tog_cmd <= '0;
      case (state)
        S_INIT: begin
          if (init_idx == INIT_W'(N_GROUPS)) begin
            state <= S_IDLE;
          end else begin
            cur_group <= GIDX_W'(init_idx);
            tgt_on    <= 1'b0;
            ext       <= 1'b0;
            init_idx  <= init_idx + 1'b1;
            state     <= S_CHECK;
          end
        end
        S_IDLE: begin
          if (req_valid) begin
            cur_group <= req_group;
            tgt_on    <= req_on;
            ext       <= 1'b1;
            state     <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!grp_ok || (cur_on == tgt_on)) begin
            state <= S_FINISH;
          end else begin
            part_rst[grp_id] <= 1'b1;
            state            <= S_TOGGLE;
          end
        end
        S_TOGGLE: begin
          tog_cmd <= {1'b1, grp_id};
          state   <= S_WAITPWR;
        end
        S_WAITPWR: begin
          if (cur_on == tgt_on) state <= tgt_on ? S_CLKON : S_FINISH;
        end
        S_CLKON: begin
          part_clk_en[grp_id] <= 1'b1;
          state               <= S_DELAY;
        end
        S_DELAY: begin
          if (dly_zero) state <= S_CLAMP;
        end
        S_CLAMP: state <= S_CLWAIT;
        S_CLWAIT: begin
          if (clamp_idle) state <= S_RSTOFF;
        end
        S_RSTOFF: begin
          part_rst[grp_id] <= 1'b0;
          state            <= S_CLKOFF;
        end
        S_CLKOFF: begin
          part_clk_en[grp_id] <= 1'b0;
          state               <= S_FINISH;
        end
        S_FINISH: state <= ext ? S_IDLE : S_INIT;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH) && ext;
  assign dly_load  = (state == S_CLKON);
  assign clamp_set = (state == S_CLAMP);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  toggle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_cmd[ID_W] |=> !tog_cmd[ID_W]);

  // R9
  held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_INIT && state != S_FINISH) |=> $stable(cur_group));

endmodule

// File: rtl/pgate_seq.sv
module pgate_seq #(
  parameter int N_GROUPS = 4,
  parameter int GIDX_W   = 3,
  parameter int ID_W     = 3,
  parameter int RST_DLY  = 4,
  parameter logic [N_GROUPS*ID_W-1:0] GROUP_ID = {3'd5, 3'd2, 3'd4, 3'd1},
  parameter logic [N_GROUPS-1:0] GROUP_OK = 4'b1011,
  parameter int SWAP_A = 0,
  parameter int SWAP_B = 1,
  localparam int N_PART = 1 << ID_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [GIDX_W-1:0]   req_group,
  input  logic                req_on,
  output logic                busy,
  output logic                done,
  output logic [ID_W:0]       pwr_tog_cmd,
  input  logic [N_PART-1:0]   pwr_status,
  output logic [N_PART-1:0]   clamp_cmd,
  input  logic [N_PART-1:0]   clamp_ack,
  output logic [N_PART-1:0]   part_rst,
  output logic [N_PART-1:0]   part_clk_en,
  output logic [N_GROUPS-1:0] grp_on
);

  logic [GIDX_W-1:0] cur_group;
  logic              grp_ok;
  logic [ID_W-1:0]   grp_id;
  logic [N_PART-1:0] grp_mask;
  logic              clamp_set;
  logic              clamp_idle;
  logic              dly_load;
  logic              dly_zero;

  pgate_map #(
    .N_GROUPS(N_GROUPS), .GIDX_W(GIDX_W), .ID_W(ID_W), .N_PART(N_PART),
    .GROUP_ID(GROUP_ID), .GROUP_OK(GROUP_OK), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
  ) map_i (
    .sel(cur_group), .pwr_status(pwr_status), .sel_ok(grp_ok),
    .sel_id(grp_id), .sel_mask(grp_mask), .grp_on(grp_on)
  );

  pgate_fsm #(
    .N_GROUPS(N_GROUPS), .GIDX_W(GIDX_W), .ID_W(ID_W), .N_PART(N_PART)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_group(req_group),
    .req_on(req_on), .req_ready(req_ready), .busy(busy), .done(done),
    .cur_group(cur_group), .grp_ok(grp_ok), .grp_id(grp_id),
    .pwr_status(pwr_status), .tog_cmd(pwr_tog_cmd), .clamp_set(clamp_set),
    .clamp_idle(clamp_idle), .dly_load(dly_load), .dly_zero(dly_zero),
    .part_rst(part_rst), .part_clk_en(part_clk_en)
  );

  pgate_delay #(.RST_DLY(RST_DLY)) dly_i (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .zero(dly_zero)
  );

  pgate_clamp #(.N_PART(N_PART)) clamp_i (
    .clk(clk), .rst_n(rst_n), .set(clamp_set), .mask(grp_mask),
    .ack(clamp_ack), .cmd(clamp_cmd), .idle(clamp_idle)
  );

  // R8
  clamp_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_cmd & ~part_rst) == '0);

  for (genvar i = 0; i < N_PART; i++) begin : g_part
    // R5
    clock_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_clk_en[i]) |-> part_rst[i]);
  end

endmodule

// File: tb/pgate_seq_tb_top.sv
`timescale 1ns/1ps
module pgate_seq_tb_top;

  localparam int RST_DLY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_group = '0;
  logic       req_on = 1'b0;
  logic       busy, done;
  logic [3:0] pwr_tog_cmd;
  logic [7:0] pwr_status = 8'hFF;
  logic [7:0] clamp_cmd;
  logic [7:0] clamp_ack = '0;
  logic [7:0] part_rst, part_clk_en;
  logic [3:0] grp_on;

  always #4 clk = ~clk;

  pgate_seq #(.RST_DLY(RST_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_group(req_group), .req_on(req_on), .busy(busy), .done(done),
    .pwr_tog_cmd(pwr_tog_cmd), .pwr_status(pwr_status), .clamp_cmd(clamp_cmd),
    .clamp_ack(clamp_ack), .part_rst(part_rst), .part_clk_en(part_clk_en),
    .grp_on(grp_on)
  );

  // switch and isolation models
  int         sw_cnt = 0;
  logic [2:0] sw_id = '0;
  logic [7:0] ack_d1 = '0;
  always @(posedge clk) begin
    if (pwr_tog_cmd[3]) begin
      sw_id  <= pwr_tog_cmd[2:0];
      sw_cnt <= 3;
    end else if (sw_cnt == 1) begin
      pwr_status[sw_id] <= ~pwr_status[sw_id];
      sw_cnt <= 0;
    end else if (sw_cnt > 1) begin
      sw_cnt <= sw_cnt - 1;
    end
    ack_d1    <= clamp_cmd;
    clamp_ack <= ack_d1;
  end

  // cycle counter and event monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  int busy_rise, tog_cnt, tog_cyc, tog_val, rst_chg, rst_rise, rst_fall;
  int clk_rise, clk_fall, clamp_rise, clamp_val, clamp_zero, stat_chg, done_cyc;
  int done_cnt = 0;
  logic       p_busy = 1'b0;
  logic [7:0] p_rst = '0, p_clk = '0, p_clamp = '0, p_stat = 8'hFF;

  task automatic clear_marks();
    busy_rise = -1; tog_cnt = 0; tog_cyc = -1; tog_val = -1; rst_chg = 0;
    rst_rise = -1; rst_fall = -1; clk_rise = -1; clk_fall = -1;
    clamp_rise = -1; clamp_val = -1; clamp_zero = -1; stat_chg = -1; done_cyc = -1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !p_busy) busy_rise = cyc;
      if (pwr_tog_cmd[3]) begin tog_cnt++; tog_cyc = cyc; tog_val = int'(pwr_tog_cmd); end
      if (part_rst != p_rst) begin
        rst_chg++;
        if ((part_rst & ~p_rst) != 0) rst_rise = cyc; else rst_fall = cyc;
      end
      if (part_clk_en != p_clk) begin
        if ((part_clk_en & ~p_clk) != 0) clk_rise = cyc; else clk_fall = cyc;
      end
      if (clamp_cmd != 0 && p_clamp == 0) begin clamp_rise = cyc; clamp_val = int'(clamp_cmd); end
      if (clamp_cmd == 0 && p_clamp != 0) clamp_zero = cyc;
      if (pwr_status != p_stat) stat_chg = cyc;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
    p_busy = busy; p_rst = part_rst; p_clk = part_clk_en;
    p_clamp = clamp_cmd; p_stat = pwr_status;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int g);
    return (g == 0) || (g == 1) || (g == 3);
  endfunction
  function automatic int exp_id(input int g);
    return (g == 0) ? 1 : (g == 1) ? 4 : (g == 3) ? 5 : 2;
  endfunction
  function automatic int exp_mask(input int g);
    return (g == 0) ? (1 << 4) : (g == 1) ? (1 << 1) : (1 << 5);
  endfunction

  logic [7:0] exp_stat = 8'hCD;

  task automatic run_req(input int g, input bit on);
    int id; bit ok; bit seq; int t; int d0;
    ok = exp_ok(g); id = exp_id(g);
    seq = ok && (exp_stat[id] != on);
    clear_marks();
    d0 = done_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_group = 3'(g); req_on = on;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done_cyc < 0 && t < 400) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 one done per request", done_cnt - d0, 1);
    if (!seq) begin
      chk(done_cyc == busy_rise + 1, ok ? "R2 no-op done timing" : "R3 ignored done timing",
          done_cyc - busy_rise, 1);
      chk(tog_cnt == 0 && rst_chg == 0, ok ? "R2 no toggle or reset" : "R3 no toggle or reset",
          tog_cnt + rst_chg, 0);
    end else begin
      chk(tog_cyc == busy_rise + 2, "R4 toggle timing", tog_cyc - busy_rise, 2);
      chk(tog_val == 8 + id, "R4 toggle command", tog_val, 8 + id);
      chk(tog_cnt == 1, "R4 single toggle", tog_cnt, 1);
      if (!on) begin
        chk(rst_rise == busy_rise + 1, "R4 reset asserted", rst_rise - busy_rise, 1);
        chk(done_cyc == stat_chg + 1, "R4 done after power drop", done_cyc - stat_chg, 1);
        chk(part_rst[id] == 1'b1 && clk_rise < 0, "R4 reset kept, no clock",
            int'(part_rst[id]), 1);
      end else begin
        chk(clk_rise == stat_chg + 2, "R5 clock after power-good", clk_rise - stat_chg, 2);
        chk(clamp_rise == clk_rise + RST_DLY + 1, "R6 propagation delay",
            clamp_rise - clk_rise, RST_DLY + 1);
        chk(clamp_val == exp_mask(g), "R7 clamp mask", clamp_val, exp_mask(g));
        chk(rst_fall == clamp_zero + 2, "R8 reset release", rst_fall - clamp_zero, 2);
        chk(clk_fall == rst_fall + 1, "R8 clock off after reset", clk_fall - rst_fall, 1);
        chk(done_cyc == clk_fall, "R8 done with clock off", done_cyc, clk_fall);
        chk(part_rst[id] == 1'b0 && part_clk_en == 0, "R8 final outputs",
            int'(part_rst[id]), 0);
      end
      exp_stat[id] = on;
    end
    chk(pwr_status == exp_stat, "R11 partition state", int'(pwr_status), int'(exp_stat));
    if (g < 4) begin
      chk(grp_on[g] == (ok ? exp_stat[id] : 1'b1),
          ok ? "R11 group view" : "R3 unsupported reads on", int'(grp_on[g]),
          ok ? int'(exp_stat[id]) : 1);
    end
  endtask

  bit finished = 1'b0;
  always @(posedge clk) begin
    if (!finished && cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d0; int t; bit refused;
    clear_marks();
    repeat (3) @(negedge clk);
    chk(part_rst == 0 && part_clk_en == 0 && clamp_cmd == 0, "R1 reset outputs",
        int'(part_rst | part_clk_en | clamp_cmd), 0);
    chk(!done && !req_ready, "R1 reset handshake", int'(done) + int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 sweep blocks requests", int'(req_ready), 0);
    t = 0;
    while (!req_ready && t < 400) begin @(negedge clk); t++; end
    chk(pwr_status == 8'hCD, "R1 sweep result", int'(pwr_status), 8'hCD);
    chk(part_rst == 8'h32, "R1 sweep resets", int'(part_rst), 8'h32);
    chk(done_cnt == 0, "R1 no done in sweep", done_cnt, 0);

    for (int g = 0; g < 8; g++) begin
      run_req(g, 1'b1);
      run_req(g, 1'b1);
      run_req(g, 1'b0);
      run_req(g, 1'b0);
    end

    // R9: requests presented while busy are refused
    run_req(3, 1'b1);
    run_req(3, 1'b0);
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_group = 3'd3; req_on = 1'b1;
    @(negedge clk);
    req_group = 3'd0;
    refused = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (req_ready) refused = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(refused && busy, "R9 ready low while busy", int'(refused), 1);
    t = 0;
    while (busy && t < 400) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 refused request left no done", done_cnt - d0, 1);
    chk(pwr_status[1] == 1'b0 && pwr_status[5] == 1'b1, "R9 only first request ran",
        int'(pwr_status), int'(8'hED));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule